// File: doc/BRIEF.md
# Rotation-Aware Block Transfer Engine

The engine copies whole pages of 16 words between a banked shared memory and a core's 512-entry local register file. It can copy in either direction. The shared memory rotates: in every clock exactly one of its 16 banks is aligned with this core, and the number of that bank arrives on the `slot` input. The engine does not wait for a chosen bank. On its first beat of a page it takes whichever bank is aligned and then follows the rotation. A page therefore fills or drains in rotation order and finishes after exactly 16 beats with no alignment stall. The engine then moves to the next memory page and the next group of 16 registers.

A command is a 10-bit descriptor plus a memory word address. It is accepted with a single-cycle `start` while the engine is idle. A fixed setup phase comes before the first beat. From acceptance to completion the timing is fully deterministic, so software can predict the end of a transfer to the clock. The engine uses the single-access memory path, one word per beat, and no streaming buffer.

The beat strobes (`mem_valid`, `rf_we`, `rf_re`) are valid-only streams with no ready. The rotation cannot be held, so back-pressure is not possible. Whatever sits on the far side of each port must accept or supply one word in every cycle its strobe is high. Read data on both ports is taken combinationally in the same cycle as the address.

Top module: `blk_xfer_engine`

## Requirements
- R1: The descriptor bits [9:5] give the register base in groups of 16 registers. Bits [4:0] give the page count minus one, so a count field of 30 moves 31 pages.
- R2: The low 4 bits of `cmd_addr` are ignored. The first page starts at `cmd_addr` with those bits forced to zero.
- R3: `busy` rises in the clock after `start` is accepted and stays high for exactly 5 + 16×pages clocks. The first 5 of those clocks carry no beat, and every later one carries exactly one beat.
- R4: The engine requires `slot` to advance by one, modulo 16, each clock. In beat j of page k, `mem_addr` equals (first page + k)×16 + `slot`, whatever the slot value at the first beat.
- R5: In page k the register index is ((base + k)×16 + `slot`) modulo 512. Indices wrap past the end of the register file.
- R6: With `to_mem`=0, each beat drives `mem_valid`=1 with `mem_we`=0 and `rf_we`=1. `rf_wdata` equals `mem_rdata` of the same clock.
- R7: With `to_mem`=1, each beat drives `rf_re`=1 and `mem_valid`=1 with `mem_we`=1. `mem_wdata` equals `rf_rdata` of the same clock.
- R8: `done` is high for exactly one clock, the clock after the last beat, and `busy` is low in that clock.
- R9: While busy, `start` is ignored, along with the descriptor, address and direction presented with it. The running transfer continues unchanged.
- R10: After reset, `busy`, `done` and all beat strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Accept a command when idle |
| to_mem | input | 1 | 0: memory to registers, 1: registers to memory |
| desc | input | 10 | Register group base [9:5], pages minus one [4:0] |
| cmd_addr | input | 20 | Memory word address of the first page |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-clock completion pulse |
| slot | input | 4 | Bank currently aligned with this core |
| mem_valid | output | 1 | Memory beat strobe |
| mem_we | output | 1 | Memory beat is a write |
| mem_addr | output | 20 | Memory word address of the beat |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, same clock |
| rf_we | output | 1 | Register write strobe |
| rf_waddr | output | 9 | Register write index |
| rf_wdata | output | 32 | Register write data |
| rf_re | output | 1 | Register read strobe |
| rf_raddr | output | 9 | Register read index |
| rf_rdata | input | 32 | Register read data, same clock |

## Verification
The bench starts transfers at several different rotation positions. A design that waited for bank 0, or that indexed registers by beat count instead of by bank, would put words in the wrong registers or miss the fixed finish time. A transfer whose register groups run past index 511 checks that the index wraps rather than saturating or touching a wrong group. A start pulse in the middle of a transfer must leave the running command unchanged. The boundary beat between pages must advance the memory page and the register group together; an off-by-one there shows up as a duplicated or skipped page. A full 31-page copy is compared word for word afterwards.

// File: rtl/btx_pkg.sv
package btx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_MOVE  = 2'd2
  } btx_state_e;
endpackage

// File: rtl/btx_ctl.sv
module btx_ctl
  import btx_pkg::*;
#(
  parameter int BANK_W = 4,
  parameter int CNT_W  = 5,
  parameter int SETUP  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             dir_in,
  input  logic [CNT_W-1:0] cnt_in,
  output logic             load,
  output logic             beat,
  output logic             page_adv,
  output logic             dir_q,
  output logic             busy,
  output logic             done
);
  localparam int SET_W = (SETUP > 1) ? $clog2(SETUP) : 1;

  btx_state_e        state;
  logic [SET_W-1:0]  set_cnt;
  logic [BANK_W-1:0] beat_cnt;
  logic [CNT_W-1:0]  left;
  logic              last_beat;

  assign load      = (state == ST_IDLE) && start;
  assign beat      = (state == ST_MOVE);
  assign busy      = (state != ST_IDLE);
  assign last_beat = beat && (beat_cnt == '1);
  assign page_adv  = last_beat && (left != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      set_cnt  <= '0;
      beat_cnt <= '0;
      left     <= '0;
      dir_q    <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            state   <= ST_SETUP;
            set_cnt <= '0;
            left    <= cnt_in;
            dir_q   <= dir_in;
          end
        end
        ST_SETUP: begin
          if (set_cnt == SET_W'(SETUP - 1)) begin
            state    <= ST_MOVE;
            beat_cnt <= '0;
          end else begin
            set_cnt <= set_cnt + 1'b1;
          end
        end
        ST_MOVE: begin
          beat_cnt <= beat_cnt + 1'b1;
          if (last_beat) begin
            if (left == '0) begin
              state <= ST_IDLE;
              done  <= 1'b1;
            end else begin
              left <= left - 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R8
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  // R9
  start_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(dir_q));
endmodule

// File: rtl/btx_addr.sv
module btx_addr #(
  parameter int PAGE_W = 16,
  parameter int BANK_W = 4,
  parameter int BLK_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              adv,
  input  logic [PAGE_W-1:0] page_in,
  input  logic [BLK_W-1:0]  blk_in,
  input  logic [BANK_W-1:0] slot,
  output logic [PAGE_W+BANK_W-1:0] word_addr,
  output logic [BLK_W+BANK_W-1:0]  rf_idx
);
  logic [PAGE_W-1:0] page_q;
  logic [BLK_W-1:0]  blk_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page_q <= '0;
      blk_q  <= '0;
    end else if (load) begin
      page_q <= page_in;
      blk_q  <= blk_in;
    end else if (adv) begin
      page_q <= page_q + 1'b1;
      blk_q  <= blk_q + 1'b1;
    end
  end

  assign word_addr = {page_q, slot};
  assign rf_idx    = {blk_q, slot};
endmodule

// File: rtl/btx_route.sv
module btx_route #(
  parameter int DW   = 32,
  parameter int AW   = 20,
  parameter int RF_W = 9
) (
  input  logic            beat,
  input  logic            dir,
  input  logic [AW-1:0]   word_addr,
  input  logic [RF_W-1:0] rf_idx,
  input  logic [DW-1:0]   mem_rdata,
  input  logic [DW-1:0]   rf_rdata,
  output logic            mem_valid,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  output logic            rf_we,
  output logic [RF_W-1:0] rf_waddr,
  output logic [DW-1:0]   rf_wdata,
  output logic            rf_re,
  output logic [RF_W-1:0] rf_raddr
);
  always_comb begin
    mem_valid = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    rf_we     = 1'b0;
    rf_waddr  = '0;
    rf_wdata  = '0;
    rf_re     = 1'b0;
    rf_raddr  = '0;
    if (beat) begin
      mem_valid = 1'b1;
      mem_addr  = word_addr;
      if (dir) begin
        rf_re     = 1'b1;
        rf_raddr  = rf_idx;
        mem_we    = 1'b1;
        mem_wdata = rf_rdata;
      end else begin
        rf_we    = 1'b1;
        rf_waddr = rf_idx;
        rf_wdata = mem_rdata;
      end
    end
  end

  // R6 R7
  one_dir_chk: assert final (!(rf_we && mem_we));
endmodule

// File: rtl/blk_xfer_engine.sv
module blk_xfer_engine #(
  parameter int DW       = 32,
  parameter int AW       = 20,
  parameter int BANKS    = 16,
  parameter int RF_DEPTH = 512,
  parameter int CNT_W    = 5,
  parameter int SETUP    = 5,
  localparam int BANK_W  = $clog2(BANKS),
  localparam int RF_W    = $clog2(RF_DEPTH),
  localparam int BLK_W   = RF_W - BANK_W,
  localparam int DESC_W  = BLK_W + CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              to_mem,
  input  logic [DESC_W-1:0] desc,
  input  logic [AW-1:0]     cmd_addr,
  output logic              busy,
  output logic              done,
  input  logic [BANK_W-1:0] slot,
  output logic              mem_valid,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_wdata,
  input  logic [DW-1:0]     mem_rdata,
  output logic              rf_we,
  output logic [RF_W-1:0]   rf_waddr,
  output logic [DW-1:0]     rf_wdata,
  output logic              rf_re,
  output logic [RF_W-1:0]   rf_raddr,
  input  logic [DW-1:0]     rf_rdata
);
  logic            load, beat, page_adv, dir_q;
  logic [AW-1:0]   word_addr;
  logic [RF_W-1:0] rf_idx;
  logic            unused_lo;

  assign unused_lo = ^cmd_addr[BANK_W-1:0];

  btx_ctl #(.BANK_W(BANK_W), .CNT_W(CNT_W), .SETUP(SETUP)) u_ctl (
    .clk(clk), .rst_n(rst_n), .start(start), .dir_in(to_mem),
    .cnt_in(desc[CNT_W-1:0]), .load(load), .beat(beat),
    .page_adv(page_adv), .dir_q(dir_q), .busy(busy), .done(done)
  );

  btx_addr #(.PAGE_W(AW - BANK_W), .BANK_W(BANK_W), .BLK_W(BLK_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .load(load), .adv(page_adv),
    .page_in(cmd_addr[AW-1:BANK_W]), .blk_in(desc[DESC_W-1:CNT_W]),
    .slot(slot), .word_addr(word_addr), .rf_idx(rf_idx)
  );

  btx_route #(.DW(DW), .AW(AW), .RF_W(RF_W)) u_route (
    .beat(beat), .dir(dir_q), .word_addr(word_addr), .rf_idx(rf_idx),
    .mem_rdata(mem_rdata), .rf_rdata(rf_rdata),
    .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .rf_we(rf_we), .rf_waddr(rf_waddr),
    .rf_wdata(rf_wdata), .rf_re(rf_re), .rf_raddr(rf_raddr)
  );

  // R3
  beat_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid || rf_we || rf_re) |-> busy);
  // R4
  slot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (slot == $past(slot) + 1'b1));
  // R5
  lane_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we || rf_re) |-> ((rf_we ? rf_waddr[BANK_W-1:0] : rf_raddr[BANK_W-1:0])
                          == mem_addr[BANK_W-1:0]));
endmodule

// File: tb/test_blk_xfer_engine.sv
module test_blk_xfer_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        to_mem = 1'b0;
  logic [9:0]  desc = '0;
  logic [19:0] cmd_addr = '0;
  logic [3:0]  slot = 4'd7;
  logic        busy, done, mem_valid, mem_we, rf_we, rf_re;
  logic [19:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata, rf_wdata, rf_rdata;
  logic [8:0]  rf_waddr, rf_raddr;

  logic [31:0] bmem [0:1023];
  logic [31:0] brf  [0:511];

  int total = 0;
  int bad = 0;
  bit chk_on = 1'b0;

  // reference model state
  bit r_act = 1'b0;
  int r_cyc, r_pages, r_base, r_page;
  bit r_dir;

  always #4 clk = ~clk;

  always @(posedge clk) slot <= slot + 4'd1;

  assign mem_rdata = bmem[mem_addr[9:0]];
  assign rf_rdata  = brf[rf_raddr];

  always @(posedge clk) begin
    if (mem_we) bmem[mem_addr[9:0]] <= mem_wdata;
    if (rf_we)  brf[rf_waddr] <= rf_wdata;
  end

  blk_xfer_engine i_blk_xfer_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .to_mem(to_mem), .desc(desc),
    .cmd_addr(cmd_addr), .busy(busy), .done(done), .slot(slot),
    .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .rf_we(rf_we),
    .rf_waddr(rf_waddr), .rf_wdata(rf_wdata), .rf_re(rf_re),
    .rf_raddr(rf_raddr), .rf_rdata(rf_rdata)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural reference: counts clocks since the accepted start
  always @(posedge clk) begin
    if (!rst_n) begin
      r_act <= 1'b0;
    end else if (start && (!r_act || r_cyc == 6 + 16 * r_pages)) begin
      r_act   <= 1'b1;
      r_cyc   <= 1;
      r_pages <= int'(desc[4:0]) + 1;
      r_base  <= int'(desc[9:5]);
      r_page  <= int'(cmd_addr >> 4);
      r_dir   <= to_mem;
    end else if (r_act) begin
      r_cyc <= r_cyc + 1;
      if (r_cyc + 1 > 6 + 16 * r_pages) r_act <= 1'b0;
    end
  end

  int e_k, e_addr, e_reg;
  bit e_busy, e_done, e_beat;

  always @(negedge clk) begin
    if (chk_on) begin
      e_busy = r_act && r_cyc >= 1 && r_cyc <= 5 + 16 * r_pages;
      e_beat = r_act && r_cyc >= 6 && r_cyc <= 5 + 16 * r_pages;
      e_done = r_act && r_cyc == 6 + 16 * r_pages;
      chk(busy == e_busy, "R3 busy", busy, e_busy);
      chk(done == e_done, "R8 done", done, e_done);
      chk(mem_valid == e_beat, "R3 beat", mem_valid, e_beat);
      chk(rf_we == (e_beat && !r_dir), "R6 rf_we", rf_we, e_beat && !r_dir);
      chk(mem_we == (e_beat && r_dir), "R7 mem_we", mem_we, e_beat && r_dir);
      chk(rf_re == (e_beat && r_dir), "R7 rf_re", rf_re, e_beat && r_dir);
      if (e_beat) begin
        e_k = (r_cyc - 6) / 16;
        e_addr = (r_page + e_k) * 16 + int'(slot);
        e_reg = ((r_base + e_k) * 16 + int'(slot)) % 512;
        chk(int'(mem_addr) == e_addr, "R2 R4 mem_addr", mem_addr, e_addr);
        if (!r_dir) begin
          chk(int'(rf_waddr) == e_reg, "R1 R5 rf_waddr", rf_waddr, e_reg);
          chk(rf_wdata == bmem[e_addr % 1024], "R6 data", rf_wdata, bmem[e_addr % 1024]);
        end else begin
          chk(int'(rf_raddr) == e_reg, "R1 R5 rf_raddr", rf_raddr, e_reg);
          chk(mem_wdata == brf[e_reg], "R7 data", mem_wdata, brf[e_reg]);
        end
      end
    end
  end

  task automatic launch(input bit dir, input logic [9:0] d, input logic [19:0] a, input int gap);
    repeat (gap) @(negedge clk);
    to_mem = dir; desc = d; cmd_addr = a; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic finish_xfer();
    while (r_act) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) bmem[i] = 32'hA000_0000 + i;
    for (int i = 0; i < 512; i++) brf[i] = 32'h5000_0000 + i * 3;
    repeat (3) @(negedge clk);
    // R10: quiet outputs during and just after reset
    chk(!busy && !done, "R10 status", {busy, done}, 0);
    chk(!mem_valid && !rf_we && !rf_re, "R10 strobes", {mem_valid, rf_we, rf_re}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !mem_valid, "R10 after", {busy, done, mem_valid}, 0);
    chk_on = 1'b1;
    // R2: unaligned address, two pages into groups 2..3
    launch(1'b0, {5'd2, 5'd1}, 20'h00023, 1);
    finish_xfer();
    // R7: one page from group 5 to memory 0x1F0
    launch(1'b1, {5'd5, 5'd0}, 20'h001F0, 3);
    finish_xfer();
    for (int j = 0; j < 16; j++)
      chk(bmem[496 + j] == brf[80 + j], "R7 stored", bmem[496 + j], brf[80 + j]);
    // R5 wrap: groups 30,31,0,1; R9 start pulse during the transfer
    launch(1'b0, {5'd30, 5'd3}, 20'h00100, 6);
    repeat (2) @(negedge clk);
    to_mem = 1'b1; desc = {5'd9, 5'd7}; cmd_addr = 20'h00300; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (20) @(negedge clk);
    to_mem = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    finish_xfer();
    chk(brf[0] == bmem[288], "R5 wrap", brf[0], bmem[288]);
    chk(brf[511] == bmem[287], "R5 top", brf[511], bmem[287]);
    // R1: 31 pages, memory 0..495 into registers 0x000..0x1EF
    launch(1'b0, {5'd0, 5'd30}, 20'h00000, 11);
    finish_xfer();
    for (int i = 0; i < 496; i++)
      chk(brf[i] == bmem[i], "R1 bulk", brf[i], bmem[i]);
    chk_on = 1'b0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule